// File: doc/BRIEF.md
# Shared External Memory Bus Port

This block connects a processor core with three separate memory spaces (program, X data and Y data) and an I/O space to one set of external pins. There is one 16-bit address bus and one 24-bit data bus for all of them. The core presents one access at a time, tagged with the target space. The block classifies the access. If the address belongs to the on-chip peripheral window or to an enabled internal data ROM, the access goes to the internal side and the external strobes stay quiet. Every other access is run on the external bus. Two type outputs tell the outside world which space the external access belongs to.

The length of each external access is set per space in a bus control register. A space runs either a fixed number of added wait cycles, or a strobe/wait handshake with an external device that paces the transfer through an active-low wait input. That wait input is brought into the clock domain through a synchronizer. Two memory-map selection bits follow their pins while reset is held and are frozen once reset is released.

Top module: `xbus_port`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy`, `done`, `ext_doe` and `int_sel` are 0, and `ext_rd_n`, `ext_wr_n`, `ext_bs_n`, `ext_ps_n` and `ext_xy` are 1. Reset sets every wait field to 15 and every handshake enable to 0.
- R2: `map_sel0` and `map_sel1` copy `cfg_pin0` and `cfg_pin1` on every clock edge while reset is high. They hold their value whatever the pins do afterwards.
- R3: During an external access the type outputs identify the space:
  - Program (`req_space`=0): `ext_ps_n`=0 and `ext_xy`=1.
  - X data (1): `ext_ps_n`=1 and `ext_xy`=1.
  - Y data (2): `ext_ps_n`=1 and `ext_xy`=0.
  - I/O (3): `ext_ps_n`=1 and `ext_xy`=1.
- R4: In fixed-wait mode an external access keeps `ext_rd_n` (read) or `ext_wr_n` (write) low for W+1 cycles. W is the 4-bit wait field of the space. The fields sit in `bcr_wdata` bits [3:0] (program), [7:4] (X), [11:8] (Y) and [15:12] (I/O). Bit 16+space selects handshake mode for that space.
- R5: An access is accepted on a clock edge when `req_valid` is high and `busy` is low. `busy` is high from the next cycle through the last access cycle. `done` pulses for exactly the one cycle that follows. A request raised while `busy` is high is ignored.
- R6: A read returns the value of `ext_din` (external) or `int_rdata` (internal) present in its last access cycle on `rdata` while `done` is high. An external write drives `req_wdata` on `ext_dout` with `ext_doe`=1 for the whole access.
- R7: In handshake mode `ext_bs_n` is low for the whole access. Let `ext_wt_n` be low for the first m access cycles and high after that. The access then lasts m+3 cycles, because the wait input passes through two synchronizing flip-flops.
- R8: Any X-space access to 0xFFC0..0xFFFF is internal. It lasts one cycle with `int_sel`=1 and `int_rom`=0, and the external strobes stay high. The same addresses in the other spaces go external.
- R9: With `rom_en`=1, X- or Y-space accesses to 0x0100..0x01FF are internal. They last one cycle with `int_sel`=1 and `int_rom`=1. With `rom_en`=0, or in the program space, those addresses go external.
- R10: `ext_addr`, `ext_ps_n` and `ext_xy` do not change during an access.
- R11: A bus control write made during an access does not change the length of that access. It applies from the next accepted access onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pin0 | input | 1 | Memory-map selection pin, read only during reset |
| cfg_pin1 | input | 1 | Memory-map selection pin, read only during reset |
| map_sel0 | output | 1 | Latched memory-map bit 0 |
| map_sel1 | output | 1 | Latched memory-map bit 1 |
| rom_en | input | 1 | Enables the internal data ROM windows |
| bcr_we | input | 1 | Bus control register write strobe |
| bcr_wdata | input | 20 | Wait fields and handshake enables |
| req_valid | input | 1 | Access request |
| req_space | input | 2 | Target space: 0 program, 1 X, 2 Y, 3 I/O |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 24 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 24 | Read data, valid with done |
| ext_addr | output | 16 | External address bus |
| ext_dout | output | 24 | External write data |
| ext_doe | output | 1 | External data drive enable |
| ext_din | input | 24 | External read data |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |
| ext_ps_n | output | 1 | Program-space type output, active low |
| ext_xy | output | 1 | Data-space type output, 1 for X, 0 for Y |
| ext_bs_n | output | 1 | Handshake bus strobe, active low |
| ext_wt_n | input | 1 | Handshake wait input, active low, asynchronous |
| int_sel | output | 1 | Internal (peripheral or ROM) access cycle |
| int_rom | output | 1 | Internal access targets the data ROM |
| int_we | output | 1 | Internal access is a write |
| int_addr | output | 16 | Internal access address |
| int_wdata | output | 24 | Internal write data |
| int_rdata | input | 24 | Internal read data |

## Verification
The embedded checks rely on four properties of the environment:
- The core raises `req_valid` for one cycle and does not expect a second access to overlap the first.
- `rom_en` changes only between accesses.
- `ext_wt_n` moves only on the falling clock edge, so the synchronizer never sees a changing input.
- The mode pins matter only while reset is held.

The stimulus keeps to these rules: it changes every input at the falling edge and changes `rom_en` only while idle. Deliberately stray requests and control writes are placed only inside a long access, so that they can be told apart from a genuine back-to-back request.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;

    localparam int unsigned AW     = 16;
    localparam int unsigned DW     = 24;
    localparam int unsigned WSW    = 4;
    localparam int unsigned NSPACE = 4;
    localparam int unsigned SPW    = $clog2(NSPACE);
    localparam int unsigned BCR_W  = NSPACE * WSW + NSPACE;

    typedef enum logic [SPW-1:0] {
        SP_PROG = 2'd0,
        SP_XDAT = 2'd1,
        SP_YDAT = 2'd2,
        SP_IO   = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        RT_EXT    = 2'd0,
        RT_PERIPH = 2'd1,
        RT_ROM    = 2'd2
    } route_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_HAND  = 2'd2,
        ST_INT   = 2'd3
    } phase_e;

    typedef struct packed {
        space_e          space;
        logic            write;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   data;
    } access_t;

    typedef struct packed {
        logic ps_n;
        logic xsel;
    } kind_t;

    // Levels of the two type outputs for a given space.
    function automatic kind_t space_kind(space_e s);
        kind_t k;
        k.ps_n = (s != SP_PROG);
        k.xsel = (s != SP_YDAT);
        return k;
    endfunction

endpackage

// File: rtl/xbus_sync.sv
`timescale 1ns/1ps
module xbus_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= RST_VAL;
                else     sh <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh <= {STAGES{RST_VAL}};
                else     sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh[STAGES-1];
endmodule

// File: rtl/xbus_cfg.sv
`timescale 1ns/1ps
module xbus_cfg
    import xbus_pkg::*;
#(
    parameter logic [WSW-1:0] WS_RESET = '1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pin0,
    input  logic                         pin1,
    input  logic                         bcr_we,
    input  logic [BCR_W-1:0]             bcr_wdata,
    output logic                         sel0,
    output logic                         sel1,
    output logic [NSPACE-1:0][WSW-1:0]   ws,
    output logic [NSPACE-1:0]            hs_en
);

    // Map selection bits track their pins only while reset is held.
    always_ff @(posedge clk) begin
        if (rst) begin
            sel0 <= pin0;
            sel1 <= pin1;
        end
    end

    // Bus control register: one wait field and one handshake bit per space.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSPACE; i++) begin
                ws[i]    <= WS_RESET;
                hs_en[i] <= 1'b0;
            end
        end else if (bcr_we) begin
            for (int i = 0; i < NSPACE; i++) begin
                ws[i]    <= bcr_wdata[i*WSW +: WSW];
                hs_en[i] <= bcr_wdata[NSPACE*WSW + i];
            end
        end
    end

    assert_map_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($stable(sel0) && $stable(sel1)));

    assert_bcr_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !bcr_we |=> ($stable(ws) && $stable(hs_en)));

endmodule

// File: rtl/xbus_decode.sv
`timescale 1ns/1ps
module xbus_decode
    import xbus_pkg::*;
#(
    parameter logic [AW-1:0] PERIPH_LO = 16'hFFC0,
    parameter logic [AW-1:0] ROM_LO    = 16'h0100,
    parameter logic [AW-1:0] ROM_HI    = 16'h01FF
) (
    input  space_e                       space,
    input  logic [AW-1:0]                addr,
    input  logic                         rom_en,
    input  logic [NSPACE-1:0][WSW-1:0]   ws,
    input  logic [NSPACE-1:0]            hs_en,
    output route_e                       route,
    output logic [WSW-1:0]               wcount,
    output logic                         use_hs
);
    logic periph_hit;
    logic rom_hit;

    // Peripheral window runs up to the top of the X space.
    assign periph_hit = (space == SP_XDAT) && (addr >= PERIPH_LO);
    assign rom_hit    = rom_en && ((space == SP_XDAT) || (space == SP_YDAT))
                        && (addr >= ROM_LO) && (addr <= ROM_HI);

    always_comb begin
        if (periph_hit)   route = RT_PERIPH;
        else if (rom_hit) route = RT_ROM;
        else              route = RT_EXT;
    end

    assign wcount = ws[space];
    assign use_hs = hs_en[space];
endmodule

// File: rtl/xbus_seq.sv
`timescale 1ns/1ps
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  access_t          req,
    input  route_e           route,
    input  logic [WSW-1:0]   wcount,
    input  logic             use_hs,
    input  logic             wt_ready,
    input  logic [DW-1:0]    ext_din,
    input  logic [DW-1:0]    int_rdata,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rdata,
    output logic [AW-1:0]    ext_addr,
    output logic [DW-1:0]    ext_dout,
    output logic             ext_doe,
    output logic             ext_rd_n,
    output logic             ext_wr_n,
    output logic             ext_ps_n,
    output logic             ext_xy,
    output logic             ext_bs_n,
    output logic             int_sel,
    output logic             int_rom,
    output logic             int_we,
    output logic [AW-1:0]    int_addr,
    output logic [DW-1:0]    int_wdata
);
    localparam int unsigned AGE_W = $clog2(SYNC_STAGES + 1);
    localparam logic [AGE_W-1:0] AGE_FULL = AGE_W'(SYNC_STAGES);

    phase_e           st;
    access_t          cur;
    logic [WSW-1:0]   cnt;
    logic [AGE_W-1:0] age;
    logic             cur_rom;
    logic             ext_active;
    kind_t            kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cur     <= '0;
            cnt     <= '0;
            age     <= '0;
            cur_rom <= 1'b0;
            done    <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur     <= req;
                        cnt     <= wcount;
                        age     <= '0;
                        cur_rom <= (route == RT_ROM);
                        if (route != RT_EXT) st <= ST_INT;
                        else if (use_hs)     st <= ST_HAND;
                        else                 st <= ST_FIXED;
                    end
                end
                ST_FIXED: begin
                    if (cnt == '0) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                        if (!cur.write) rdata <= ext_din;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HAND: begin
                    // The synchronizer output must hold a sample taken after the strobe.
                    if ((age == AGE_FULL) && wt_ready) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                        if (!cur.write) rdata <= ext_din;
                    end else if (age != AGE_FULL) begin
                        age <= age + 1'b1;
                    end
                end
                ST_INT: begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                    if (!cur.write) rdata <= int_rdata;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign ext_active = (st == ST_FIXED) || (st == ST_HAND);
    assign kind       = space_kind(cur.space);

    assign busy      = (st != ST_IDLE);
    assign ext_addr  = cur.addr;
    assign ext_dout  = cur.data;
    assign ext_doe   = ext_active && cur.write;
    assign ext_rd_n  = !(ext_active && !cur.write);
    assign ext_wr_n  = !(ext_active && cur.write);
    assign ext_bs_n  = (st != ST_HAND);
    assign ext_ps_n  = ext_active ? kind.ps_n : 1'b1;
    assign ext_xy    = ext_active ? kind.xsel : 1'b1;
    assign int_sel   = (st == ST_INT);
    assign int_rom   = int_sel && cur_rom;
    assign int_we    = int_sel && cur.write;
    assign int_addr  = cur.addr;
    assign int_wdata = cur.data;

    assert_done_follows_busy_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    assert_bus_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(ext_addr) && $stable(ext_ps_n) && $stable(ext_xy)));

    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!ext_rd_n, !ext_wr_n, int_sel}));

    assert_bs_with_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        !ext_bs_n |-> (!ext_rd_n || !ext_wr_n));

    assert_internal_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        int_sel |-> (ext_rd_n && ext_wr_n && ext_bs_n && !ext_doe));

    assert_strobe_only_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (!ext_rd_n || !ext_wr_n) |-> busy);

endmodule

// File: rtl/xbus_port.sv
`timescale 1ns/1ps
module xbus_port
    import xbus_pkg::*;
#(
    parameter logic [AW-1:0]  PERIPH_LO   = 16'hFFC0,
    parameter logic [AW-1:0]  ROM_LO      = 16'h0100,
    parameter logic [AW-1:0]  ROM_HI      = 16'h01FF,
    parameter logic [WSW-1:0] WS_RESET    = 4'hF,
    parameter int unsigned    SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_pin0,
    input  logic              cfg_pin1,
    output logic              map_sel0,
    output logic              map_sel1,
    input  logic              rom_en,
    input  logic              bcr_we,
    input  logic [BCR_W-1:0]  bcr_wdata,
    input  logic              req_valid,
    input  logic [SPW-1:0]    req_space,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DW-1:0]     rdata,
    output logic [AW-1:0]     ext_addr,
    output logic [DW-1:0]     ext_dout,
    output logic              ext_doe,
    input  logic [DW-1:0]     ext_din,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    output logic              ext_ps_n,
    output logic              ext_xy,
    output logic              ext_bs_n,
    input  logic              ext_wt_n,
    output logic              int_sel,
    output logic              int_rom,
    output logic              int_we,
    output logic [AW-1:0]     int_addr,
    output logic [DW-1:0]     int_wdata,
    input  logic [DW-1:0]     int_rdata
);
    logic [NSPACE-1:0][WSW-1:0] ws;
    logic [NSPACE-1:0]          hs_en;
    access_t                    req_s;
    route_e                     route;
    logic [WSW-1:0]             wcount;
    logic                       use_hs;
    logic                       wt_ready;

    assign req_s.space = space_e'(req_space);
    assign req_s.write = req_write;
    assign req_s.addr  = req_addr;
    assign req_s.data  = req_wdata;

    xbus_cfg #(.WS_RESET(WS_RESET)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .pin0      (cfg_pin0),
        .pin1      (cfg_pin1),
        .bcr_we    (bcr_we),
        .bcr_wdata (bcr_wdata),
        .sel0      (map_sel0),
        .sel1      (map_sel1),
        .ws        (ws),
        .hs_en     (hs_en)
    );

    xbus_decode #(
        .PERIPH_LO (PERIPH_LO),
        .ROM_LO    (ROM_LO),
        .ROM_HI    (ROM_HI)
    ) u_dec (
        .space  (req_s.space),
        .addr   (req_s.addr),
        .rom_en (rom_en),
        .ws     (ws),
        .hs_en  (hs_en),
        .route  (route),
        .wcount (wcount),
        .use_hs (use_hs)
    );

    xbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wsync (
        .clk (clk),
        .rst (rst),
        .d   (ext_wt_n),
        .q   (wt_ready)
    );

    xbus_seq #(.SYNC_STAGES(SYNC_STAGES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req_s),
        .route     (route),
        .wcount    (wcount),
        .use_hs    (use_hs),
        .wt_ready  (wt_ready),
        .ext_din   (ext_din),
        .int_rdata (int_rdata),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .ext_addr  (ext_addr),
        .ext_dout  (ext_dout),
        .ext_doe   (ext_doe),
        .ext_rd_n  (ext_rd_n),
        .ext_wr_n  (ext_wr_n),
        .ext_ps_n  (ext_ps_n),
        .ext_xy    (ext_xy),
        .ext_bs_n  (ext_bs_n),
        .int_sel   (int_sel),
        .int_rom   (int_rom),
        .int_we    (int_we),
        .int_addr  (int_addr),
        .int_wdata (int_wdata)
    );

endmodule

// File: tb/sim_xbus_port.sv
`timescale 1ns/1ps
module sim_xbus_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_pin0 = 1'b1, cfg_pin1 = 1'b0;
    logic        map_sel0, map_sel1;
    logic        rom_en = 1'b0;
    logic        bcr_we = 1'b0;
    logic [19:0] bcr_wdata = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_space = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [23:0] req_wdata = '0;
    logic        busy, done;
    logic [23:0] rdata;
    logic [15:0] ext_addr;
    logic [23:0] ext_dout;
    logic        ext_doe;
    logic [23:0] ext_din = '0;
    logic        ext_rd_n, ext_wr_n, ext_ps_n, ext_xy, ext_bs_n;
    logic        ext_wt_n = 1'b1;
    logic        int_sel, int_rom, int_we;
    logic [15:0] int_addr;
    logic [23:0] int_wdata;
    logic [23:0] int_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int seq_no   = 0;

    // Reference configuration state, kept by the bench.
    int m_ws [4];
    bit m_hs [4];

    always #10 clk = ~clk;

    xbus_port u0 (
        .clk(clk), .rst(rst), .cfg_pin0(cfg_pin0), .cfg_pin1(cfg_pin1),
        .map_sel0(map_sel0), .map_sel1(map_sel1), .rom_en(rom_en),
        .bcr_we(bcr_we), .bcr_wdata(bcr_wdata), .req_valid(req_valid),
        .req_space(req_space), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
        .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe),
        .ext_din(ext_din), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_ps_n(ext_ps_n), .ext_xy(ext_xy), .ext_bs_n(ext_bs_n),
        .ext_wt_n(ext_wt_n), .int_sel(int_sel), .int_rom(int_rom),
        .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
        .int_rdata(int_rdata)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // 0 external, 1 peripheral window, 2 data ROM
    function automatic int ref_route(input int sp, input int addr);
        if (sp == 1 && addr >= 'hFFC0) return 1;
        if (rom_en && (sp == 1 || sp == 2) && addr >= 'h0100 && addr <= 'h01FF) return 2;
        return 0;
    endfunction

    task automatic write_bcr(input logic [19:0] v);
        @(negedge clk);
        bcr_we = 1'b1; bcr_wdata = v;
        @(negedge clk);
        bcr_we = 1'b0;
        for (int i = 0; i < 4; i++) begin
            m_ws[i] = int'(v[i*4 +: 4]);
            m_hs[i] = v[16+i];
        end
    endtask

    task automatic run_access(input int sp, input bit wr, input int addr, input int m,
                              input bit poke, input bit cfg_mid, input logic [19:0] cfg_val,
                              input string tag);
        int rt, dur;
        bit hs;
        logic [23:0] wd, dinv, irdv;
        seq_no++;
        rt = ref_route(sp, addr);
        hs = m_hs[sp];
        if (rt != 0)  dur = 1;
        else if (hs)  dur = m + 3;
        else          dur = m_ws[sp] + 1;
        wd   = 24'h300000 + 24'(seq_no * 7);
        dinv = 24'hC00000 ^ 24'(addr);
        irdv = 24'h5A0000 + 24'(addr);
        @(negedge clk);
        req_valid = 1'b1; req_space = 2'(sp); req_write = wr;
        req_addr = 16'(addr); req_wdata = wd;
        ext_din = dinv; int_rdata = irdv; ext_wt_n = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 1; i <= dur; i++) begin
            ext_wt_n = (hs && i <= m) ? 1'b0 : 1'b1;
            if (poke && i == 1) begin req_valid = 1'b1; req_addr = 16'(addr ^ 'h5555); end
            if (poke && i == 2) begin req_valid = 1'b0; req_addr = 16'(addr); end
            if (cfg_mid && i == 1) begin bcr_we = 1'b1; bcr_wdata = cfg_val; end
            if (cfg_mid && i == 2) bcr_we = 1'b0;
            chk({tag, " R5 busy during access"}, 32'(busy), 32'd1);
            if (rt == 0) begin
                chk({tag, " read strobe"}, 32'(ext_rd_n), 32'(wr));
                chk({tag, " write strobe"}, 32'(ext_wr_n), 32'(!wr));
                chk({tag, " R7 bus strobe"}, 32'(ext_bs_n), 32'(!hs));
                chk({tag, " R3 ps_n"}, 32'(ext_ps_n), (sp == 0) ? 32'd0 : 32'd1);
                chk({tag, " R3 xy"}, 32'(ext_xy), (sp == 2) ? 32'd0 : 32'd1);
                chk({tag, " R10 address"}, 32'(ext_addr), 32'(addr));
                chk({tag, " R6 drive enable"}, 32'(ext_doe), 32'(wr));
                if (wr) chk({tag, " R6 write data"}, 32'(ext_dout), 32'(wd));
                chk({tag, " R8 int_sel low"}, 32'(int_sel), 32'd0);
            end else begin
                chk({tag, " int_sel"}, 32'(int_sel), 32'd1);
                chk({tag, " int_rom"}, 32'(int_rom), (rt == 2) ? 32'd1 : 32'd0);
                chk({tag, " int_we"}, 32'(int_we), 32'(wr));
                chk({tag, " int_addr"}, 32'(int_addr), 32'(addr));
                chk({tag, " R8 no ext strobe"}, 32'({ext_rd_n, ext_wr_n, ext_bs_n}), 32'd7);
            end
            @(negedge clk);
        end
        if (cfg_mid) begin
            for (int i = 0; i < 4; i++) begin
                m_ws[i] = int'(cfg_val[i*4 +: 4]);
                m_hs[i] = cfg_val[16+i];
            end
        end
        ext_wt_n = 1'b1;
        chk({tag, " R5 busy clear at end"}, 32'(busy), 32'd0);
        chk({tag, " R5 done pulse"}, 32'(done), 32'd1);
        chk({tag, " strobes idle"}, 32'({ext_rd_n, ext_wr_n, ext_bs_n}), 32'd7);
        if (!wr) chk({tag, " R6 read data"}, 32'(rdata), (rt == 0) ? 32'(dinv) : 32'(irdv));
        @(negedge clk);
        chk({tag, " R5 done single cycle / no stray access"}, 32'({done, busy}), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_ws[i] = 15; m_hs[i] = 1'b0; end
        // R1/R2: reset state and pin capture
        repeat (3) @(negedge clk);
        chk("R2 sel0 follows pin in reset", 32'(map_sel0), 32'd1);
        chk("R2 sel1 follows pin in reset", 32'(map_sel1), 32'd0);
        cfg_pin0 = 1'b0; cfg_pin1 = 1'b1;
        @(negedge clk);
        chk("R2 sel0 tracks change in reset", 32'(map_sel0), 32'd0);
        chk("R2 sel1 tracks change in reset", 32'(map_sel1), 32'd1);
        chk("R1 busy/done/doe/int_sel", 32'({busy, done, ext_doe, int_sel}), 32'd0);
        chk("R1 strobes and type outputs",
            32'({ext_rd_n, ext_wr_n, ext_bs_n, ext_ps_n, ext_xy}), 32'h1F);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", 32'({busy, done, ext_rd_n, ext_wr_n}), 32'd3);
        cfg_pin0 = 1'b1; cfg_pin1 = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 sel0 frozen", 32'(map_sel0), 32'd0);
        chk("R2 sel1 frozen", 32'(map_sel1), 32'd1);

        // R1: reset wait count of 15 gives a 16-cycle program read
        run_access(0, 1'b0, 'h0042, 0, 1'b0, 1'b0, '0, "R1 R4 reset waits");

        // R4: per-space fixed waits (P=2, X=0, Y=5, IO=1)
        write_bcr(20'h01502);
        run_access(1, 1'b0, 'h1234, 0, 1'b0, 1'b0, '0, "R4 X zero wait");
        run_access(2, 1'b1, 'h0FFF, 0, 1'b0, 1'b0, '0, "R4 Y write five waits");
        run_access(3, 1'b0, 'h0010, 0, 1'b0, 1'b0, '0, "R4 IO one wait");
        run_access(0, 1'b1, 'h2000, 0, 1'b0, 1'b0, '0, "R4 P write two waits");

        // R8: peripheral window only in X space
        run_access(1, 1'b0, 'hFFC0, 0, 1'b0, 1'b0, '0, "R8 X periph low edge");
        run_access(1, 1'b1, 'hFFFF, 0, 1'b0, 1'b0, '0, "R8 X periph top");
        run_access(1, 1'b0, 'hFFBF, 0, 1'b0, 1'b0, '0, "R8 X below window");
        run_access(2, 1'b0, 'hFFC0, 0, 1'b0, 1'b0, '0, "R8 Y same address external");
        run_access(0, 1'b0, 'hFFD0, 0, 1'b0, 1'b0, '0, "R8 P same address external");

        // R9: data ROM windows
        @(negedge clk); rom_en = 1'b1;
        run_access(1, 1'b0, 'h0100, 0, 1'b0, 1'b0, '0, "R9 X ROM low");
        run_access(2, 1'b0, 'h01FF, 0, 1'b0, 1'b0, '0, "R9 Y ROM high");
        run_access(1, 1'b0, 'h0200, 0, 1'b0, 1'b0, '0, "R9 X above ROM");
        run_access(0, 1'b0, 'h0150, 0, 1'b0, 1'b0, '0, "R9 P not ROM");
        @(negedge clk); rom_en = 1'b0;
        run_access(1, 1'b0, 'h0100, 0, 1'b0, 1'b0, '0, "R9 ROM disabled");

        // R7: handshake on Y space
        write_bcr(20'h41502);
        run_access(2, 1'b0, 'h0333, 0, 1'b0, 1'b0, '0, "R7 no wait");
        run_access(2, 1'b1, 'h0334, 4, 1'b0, 1'b0, '0, "R7 wait four");
        run_access(2, 1'b0, 'h0335, 1, 1'b0, 1'b0, '0, "R7 wait one");
        run_access(1, 1'b0, 'h0336, 0, 1'b0, 1'b0, '0, "R7 X stays fixed");

        // R5: stray request during a long access is ignored
        run_access(2, 1'b0, 'h0777, 6, 1'b1, 1'b0, '0, "R5 ignore while busy");

        // R11: control write mid-access applies only afterwards (P 2 -> 7)
        run_access(0, 1'b0, 'h0800, 0, 1'b0, 1'b1, 20'h41507, "R11 old length kept");
        run_access(0, 1'b0, 'h0801, 0, 1'b0, 1'b0, '0, "R11 new length used");

        summary();
        $finish;
    end

endmodule